// File: doc/BRIEF.md
# Daughter Allocation and Write Guard

This block governs reproduction and memory protection for a single cell of a self-replicating program machine. It sees the cell's allocate and split instruction strobes. It checks the requested daughter size against the legal range and takes a grant or a refusal from an external free-memory allocator. While a daughter exists, it holds that daughter's base address and size.

Every store the cell issues, either one byte or a two-byte word, is judged against the cell's own range and, while a daughter is pending, against the daughter's window. The verdict is returned in the same cycle. The store path suppresses any store that is denied, so memory stays unchanged.

Nothing traps. Each protocol or bounds violation adds one to a saturating error counter, which the scheduler later uses to pick cells for removal. A successful split emits a one-cycle launch pulse with the daughter's base and size, and then closes the window.

Top module: `cell_repro_guard`

## Requirements
- R1: After reset (cell creation), no daughter is pending, the error count is 0 and the launch pulse is low.
- R2: An allocate request whose size (register A, read as a 16-bit two's-complement value) is below 10 or above 512 counts one error, gives no allocation, and returns 0 as the new I value.
- R3: An allocate request with a legal size and no daughter pending returns the allocator's base as the new I value when the allocator grants; from the next cycle the daughter is pending with that base and the requested size. When the allocator refuses, it returns 0, no daughter is pending and no error is counted.
- R4: An allocate request while a daughter is pending counts exactly one error, whatever its size. It returns 0 and leaves the pending window unchanged.
- R5: A split request while a daughter is pending raises the launch output in that same cycle, with the daughter base and size presented. From the next cycle no daughter is pending.
- R6: A split request with no daughter pending counts one error and raises no launch.
- R7: A byte store to an address below the cell length N is allowed.
- R8: A byte store inside [base, base+size-1] of the daughter is allowed only while that daughter is pending. All other addresses are denied.
- R9: A word store to address a is allowed only if a and a+1 each fall in a permitted region, which may be two different regions. a = 0xFFFF is always denied, because the address does not wrap.
- R10: A denied store counts one error in the next cycle. An allowed store counts none.
- R11: The error counter saturates at 2^ERR_W-1, which is 63 by default, and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted at cell creation |
| cell_len | input | AW | Cell length N in bytes |
| op_malloc | input | 1 | Allocate instruction strobe |
| op_divide | input | 1 | Split instruction strobe |
| req_size | input | DW | Register A at allocate time |
| alloc_grant | input | 1 | Allocator grants the request this cycle |
| alloc_base | input | AW | Relative base address offered by the allocator |
| st_valid | input | 1 | Store strobe |
| st_wide | input | 1 | Store is two bytes (a, a+1) |
| st_addr | input | AW | Store relative address (register I) |
| malloc_ok | output | 1 | Allocation succeeded this cycle |
| i_value | output | AW | New value for I after an allocate |
| st_allow | output | 1 | Store permitted; memory write enable |
| pend | output | 1 | A daughter is pending |
| dtr_base | output | AW | Daughter base address |
| dtr_size | output | DW | Daughter size |
| launch | output | 1 | One-cycle split pulse |
| err_count | output | ERR_W | Saturating error counter |

## Verification
The checker covers the relations that must hold on every cycle. A grant opens the window with the returned base. A pending daughter blocks a second allocation. A launch closes the window and never occurs without a pending daughter. Every denied store raises the error event, the counter moves by exactly one per event, it holds still otherwise, and it stays put at saturation. Only the bench scenarios can show the concrete boundaries: the size limits 9/10/512/513 and negative sizes, the edges at N-1 and N, the first and last bytes of the window, word stores that straddle two regions or the top of the address space, and the window closing after a split.

// File: rtl/crg_pkg.sv
package crg_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_SIZE   = 3'd1,
    CAUSE_DOUBLE = 3'd2,
    CAUSE_ORPHAN = 3'd3,
    CAUSE_STORE  = 3'd4
  } err_cause_t;

  // Signed range test on a sign-extended request size.
  function automatic logic size_legal(input logic signed [31:0] sz,
                                      input int lo, input int hi);
    return (sz >= lo) && (sz <= hi);
  endfunction

  // Address a lies in [lo, lo+len-1]; all operands zero-extended.
  function automatic logic in_region(input logic [31:0] a,
                                     input logic [31:0] lo,
                                     input logic [31:0] len);
    return (a >= lo) && ((a - lo) < len);
  endfunction

endpackage

// File: rtl/crg_alloc.sv
module crg_alloc #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int SIZE_MIN = 10,
  parameter int SIZE_MAX = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_malloc,
  input  logic          op_divide,
  input  logic [DW-1:0] req_size,
  input  logic          alloc_grant,
  input  logic [AW-1:0] alloc_base,
  output logic          pend,
  output logic [AW-1:0] win_base,
  output logic [DW-1:0] win_size,
  output logic          malloc_ok,
  output logic [AW-1:0] i_value,
  output logic          launch,
  output logic          ev_size_bad,
  output logic          ev_double,
  output logic          ev_orphan
);
  import crg_pkg::*;

  logic size_ok;

  assign size_ok     = size_legal(32'($signed(req_size)), SIZE_MIN, SIZE_MAX);
  assign ev_double   = op_malloc & pend;
  assign ev_size_bad = op_malloc & ~pend & ~size_ok;
  assign malloc_ok   = op_malloc & ~pend & size_ok & alloc_grant;
  assign i_value     = malloc_ok ? alloc_base : '0;
  assign launch      = op_divide & pend;
  assign ev_orphan   = op_divide & ~pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      win_base <= '0;
      win_size <= '0;
    end else if (malloc_ok) begin
      pend     <= 1'b1;
      win_base <= alloc_base;
      win_size <= req_size;
    end else if (launch) begin
      pend     <= 1'b0;
    end
  end

endmodule

// File: rtl/crg_store_guard.sv
module crg_store_guard #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int LANES = 2
) (
  input  logic          pend,
  input  logic [AW-1:0] win_base,
  input  logic [DW-1:0] win_size,
  input  logic [AW-1:0] cell_len,
  input  logic          st_valid,
  input  logic          st_wide,
  input  logic [AW-1:0] st_addr,
  output logic          st_allow,
  output logic          ev_store_bad
);
  import crg_pkg::*;

  localparam logic [31:0] ADDR_TOP = 32'((64'd1 << AW) - 1);

  logic [LANES-1:0] lane_ok;
  logic [LANES-1:0] lane_used;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [31:0] a;
    logic        own_hit;
    logic        dtr_hit;
    assign a       = 32'(st_addr) + 32'(g);
    assign own_hit = in_region(a, 32'd0, 32'(cell_len));
    assign dtr_hit = pend & in_region(a, 32'(win_base), 32'(win_size));
    assign lane_used[g] = (g == 0) ? 1'b1 : st_wide;
    assign lane_ok[g]   = (a <= ADDR_TOP) & (own_hit | dtr_hit);
  end

  assign st_allow     = st_valid & (&(lane_ok | ~lane_used));
  assign ev_store_bad = st_valid & ~st_allow;

endmodule

// File: rtl/crg_err_ctr.sv
module crg_err_ctr #(
  parameter int ERR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_err,
  output logic [ERR_W-1:0] err_count
);
  localparam logic [ERR_W-1:0] CNT_MAX = {ERR_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err_count <= '0;
    else if (ev_err && (err_count != CNT_MAX))
      err_count <= err_count + 1'b1;
  end

endmodule

// File: rtl/cell_repro_guard.sv
module cell_repro_guard #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int SIZE_MIN = 10,
  parameter int SIZE_MAX = 512,
  parameter int ERR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    cell_len,
  input  logic             op_malloc,
  input  logic             op_divide,
  input  logic [DW-1:0]    req_size,
  input  logic             alloc_grant,
  input  logic [AW-1:0]    alloc_base,
  input  logic             st_valid,
  input  logic             st_wide,
  input  logic [AW-1:0]    st_addr,
  output logic             malloc_ok,
  output logic [AW-1:0]    i_value,
  output logic             st_allow,
  output logic             pend,
  output logic [AW-1:0]    dtr_base,
  output logic [DW-1:0]    dtr_size,
  output logic             launch,
  output logic [ERR_W-1:0] err_count
);
  import crg_pkg::*;

  logic       ev_size_bad, ev_double, ev_orphan, ev_store_bad;
  logic       ev_err;
  err_cause_t err_cause;

  crg_alloc #(.AW(AW), .DW(DW), .SIZE_MIN(SIZE_MIN), .SIZE_MAX(SIZE_MAX)) u_alloc (
    .clk(clk), .rst_n(rst_n),
    .op_malloc(op_malloc), .op_divide(op_divide),
    .req_size(req_size), .alloc_grant(alloc_grant), .alloc_base(alloc_base),
    .pend(pend), .win_base(dtr_base), .win_size(dtr_size),
    .malloc_ok(malloc_ok), .i_value(i_value), .launch(launch),
    .ev_size_bad(ev_size_bad), .ev_double(ev_double), .ev_orphan(ev_orphan)
  );

  crg_store_guard #(.AW(AW), .DW(DW)) u_guard (
    .pend(pend), .win_base(dtr_base), .win_size(dtr_size),
    .cell_len(cell_len), .st_valid(st_valid), .st_wide(st_wide),
    .st_addr(st_addr), .st_allow(st_allow), .ev_store_bad(ev_store_bad)
  );

  always_comb begin
    if (ev_double)         err_cause = CAUSE_DOUBLE;
    else if (ev_size_bad)  err_cause = CAUSE_SIZE;
    else if (ev_orphan)    err_cause = CAUSE_ORPHAN;
    else if (ev_store_bad) err_cause = CAUSE_STORE;
    else                   err_cause = CAUSE_NONE;
  end

  assign ev_err = (err_cause != CAUSE_NONE);

  crg_err_ctr #(.ERR_W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .ev_err(ev_err), .err_count(err_count)
  );

endmodule

// File: rtl/crg_checker.sv
module crg_checker #(
  parameter int AW = 16,
  parameter int ERR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_malloc,
  input logic             op_divide,
  input logic             st_valid,
  input logic             st_allow,
  input logic             malloc_ok,
  input logic [AW-1:0]    i_value,
  input logic             pend,
  input logic [AW-1:0]    dtr_base,
  input logic             launch,
  input logic [ERR_W-1:0] err_count,
  input logic             ev_err
);
  localparam logic [ERR_W-1:0] CMAX = {ERR_W{1'b1}};

  // R3
  a_r3_grant_opens: assert property (@(posedge clk) disable iff (!rst_n)
    malloc_ok |=> (pend && dtr_base == $past(i_value)));

  // R4
  a_r4_no_double: assert property (@(posedge clk) disable iff (!rst_n)
    (op_malloc && pend) |-> (!malloc_ok && ev_err));

  // R5
  a_r5_launch_closes: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !pend);

  // R6
  a_r6_no_orphan_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (op_divide && !pend) |-> (!launch && ev_err));

  // R10
  a_r10_deny_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_allow) |-> ev_err);

  a_r10_err_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err && err_count != CMAX) |=> (err_count == $past(err_count) + 1'b1));

  a_r10_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_err |=> $stable(err_count));

  // R11
  a_r11_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CMAX) |=> (err_count == CMAX));

endmodule

bind cell_repro_guard crg_checker #(.AW(AW), .ERR_W(ERR_W)) u_chk (.*);

// File: tb/sim_cell_repro_guard.sv
module sim_cell_repro_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cell_len = 16'd100;
  logic        op_malloc = 1'b0, op_divide = 1'b0;
  logic [15:0] req_size = '0;
  logic        alloc_grant = 1'b0;
  logic [15:0] alloc_base = '0;
  logic        st_valid = 1'b0, st_wide = 1'b0;
  logic [15:0] st_addr = '0;
  logic        malloc_ok, st_allow, pend, launch;
  logic [15:0] i_value, dtr_base, dtr_size;
  logic [5:0]  err_count;

  always #5 clk = ~clk;

  cell_repro_guard u0 (.*);

  typedef struct {
    string       tag;
    int          kind;   // 0 idle, 1 allocate, 2 split, 3 store
    logic        ok;
    logic [15:0] ival;
    logic        pend;
    int          err;
    logic        launch;
    logic [15:0] base;
    logic [15:0] size;
  } exp_t;

  exp_t q[$];
  event smp;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  // bench model state
  logic        m_pend = 1'b0;
  int          m_base = 0, m_size = 0, m_err = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit permitted(int a);
    if (a > 16'hFFFF) return 0;
    if (a < int'(cell_len)) return 1;
    if (m_pend && a >= m_base && a < m_base + m_size) return 1;
    return 0;
  endfunction

  // monitor
  initial begin
    forever begin
      exp_t e;
      @(smp);
      e = q.pop_front();
      chk(e.tag, "pend", int'(pend), int'(e.pend));
      chk(e.tag, "err_count", int'(err_count), e.err);
      chk(e.tag, "launch", int'(launch), int'(e.launch));
      if (e.kind == 1) begin
        chk(e.tag, "malloc_ok", int'(malloc_ok), int'(e.ok));
        chk(e.tag, "i_value", int'(i_value), int'(e.ival));
      end
      if (e.kind == 3) chk(e.tag, "st_allow", int'(st_allow), int'(e.ok));
      if (e.kind == 2 && e.launch) begin
        chk(e.tag, "dtr_base", int'(dtr_base), int'(e.base));
        chk(e.tag, "dtr_size", int'(dtr_size), int'(e.size));
      end
    end
  end

  // driver
  task automatic drive(string tag, int kind, logic [15:0] sz, logic gr,
                       logic [15:0] base, logic wide);
    exp_t e;
    bit   err = 0;
    @(negedge clk);
    op_malloc = (kind == 1); op_divide = (kind == 2); st_valid = (kind == 3);
    req_size = sz; alloc_grant = gr; alloc_base = base;
    st_addr = base; st_wide = wide;
    e.tag = tag; e.kind = kind; e.pend = m_pend; e.err = m_err;
    e.ok = 0; e.ival = 0; e.launch = 0; e.base = 16'(m_base); e.size = 16'(m_size);
    if (kind == 1) begin
      int s = int'($signed(sz));
      bit legal = (s >= 10) && (s <= 512);
      e.ok = !m_pend && legal && gr;
      e.ival = e.ok ? base : 16'd0;
      err = m_pend || !legal;
    end else if (kind == 2) begin
      e.launch = m_pend;
      err = !m_pend;
    end else if (kind == 3) begin
      e.ok = permitted(int'(base)) && (!wide || permitted(int'(base) + 1));
      err = !e.ok;
    end
    q.push_back(e);
    #1 -> smp;
    #1;
    // model update at coming edge
    if (kind == 1 && e.ok) begin
      m_pend = 1; m_base = int'(base); m_size = int'(sz);
    end
    if (kind == 2) m_pend = 0;
    if (err && m_err < 63) m_err++;
  endtask

  task automatic idle(string tag);      drive(tag, 0, 0, 0, 0, 0); endtask
  task automatic alloc(string tag, logic [15:0] sz, logic gr, logic [15:0] b);
    drive(tag, 1, sz, gr, b, 0);
  endtask
  task automatic split(string tag);     drive(tag, 2, 0, 0, 0, 0); endtask
  task automatic store(string tag, logic [15:0] a, logic w);
    drive(tag, 3, 0, 0, a, w);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle("R1");
    alloc("R2", 16'd9, 1, 16'd200);
    alloc("R2", 16'd513, 1, 16'd200);
    alloc("R2", 16'hFFFB, 1, 16'd200);
    alloc("R3", 16'd10, 0, 16'd200);
    idle("R3");
    split("R6");
    alloc("R3", 16'd10, 1, 16'd200);
    idle("R3");
    alloc("R4", 16'd20, 1, 16'd300);
    alloc("R4", 16'd3, 1, 16'd300);
    store("R8", 16'd150, 0);
    store("R8", 16'd200, 0);
    store("R8", 16'd209, 0);
    store("R8", 16'd210, 0);
    store("R7", 16'd99, 0);
    store("R7", 16'd0, 0);
    store("R7", 16'd100, 0);
    store("R9", 16'd99, 1);
    store("R9", 16'd208, 1);
    store("R9", 16'd209, 1);
    store("R10", 16'd50, 1);
    split("R5");
    idle("R5");
    store("R8", 16'd205, 0);
    split("R6");
    alloc("R3", 16'd512, 1, 16'd100);
    store("R9", 16'd99, 1);
    store("R9", 16'd611, 0);
    store("R9", 16'd612, 0);
    store("R9", 16'hFFFF, 1);
    split("R5");
    for (int k = 0; k < 70; k++) split("R11");
    idle("R11");
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule